// File: doc/BRIEF.md
# Power State Transition Controller

This block runs the chip-level power state machine. There are three states: OFF, ON and SLEEP. Many single-cycle event inputs drive the machine:

- supply monitors
- the watchdog
- GPIO and power-button requests
- an RTC alarm
- fault detectors
- software writes over a small register bus

The same event can mean different things in different states. An RTC alarm turns the chip on when it is OFF, and wakes it when it is in SLEEP. Turning the chip on and waking it both need the supply-OK level to be high.

The regulator start-up and shut-down timing is outside this block. The block pulses a start or stop strobe and then waits for a sequence-done handshake. While a sequence runs, the block ignores new requests. Entering SLEEP needs no handshake: a sleep-entry strobe is pulsed and the state changes at once.

Reset-class events (watchdog reset, hardware reset, software reset, converter undervoltage) run a stop sequence and then an automatic start sequence. Two write-1-to-clear registers record why the chip last turned on and why it last turned off. SLEEP entry is never recorded.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (OFF), both source registers read 0 and no strobe is high.
- R2: In OFF with `supply_ok` high, any of the following pulses `start_seq` on the next cycle, and `pwr_state` becomes 1 (ON) on the cycle after `seq_done`:
  - an RTC alarm;
  - a GPIO on request enabled by `gpio_func[0]`;
  - a button press enabled by `pin_func[0]`.
  The ON-source register is cleared and then loaded with bit0 (came from OFF) plus one bit per cause present: bit1 RTC, bit2 GPIO, bit3 button.
- R3: With `supply_ok` low, ON and WAKE requests are ignored. No strobe is pulsed and the state and the ON-source register do not change.
- R4: In ON or SLEEP, any OFF cause pulses `stop_seq` on the next cycle, and `pwr_state` becomes 0 after `seq_done`. The OFF-source register is cleared and then loaded with every cause present in that cycle. The OFF causes and their bits are:
  - bit0: software write of 0 to control bit0;
  - bit1: button with `pin_func[2]`;
  - bit2: thermal;
  - bit3: supply-monitor off;
  - bit4: supply shutdown;
  - bit5: GPIO off with `gpio_func[1]`;
  - bit6: sequence failure;
  - bit7: LDO error.
- R5: In ON, a control write with bit1 = 1, or a GPIO sleep request with `gpio_func[2]`, pulses `sleep_enter`. `pwr_state` reads 2 (SLEEP) in the same cycle as the strobe. Neither source register changes.
- R6: In SLEEP with `supply_ok` high, any wake cause pulses `start_seq`, and `pwr_state` becomes 1 after `seq_done`. The ON-source register is loaded with bit0 = 0 and one bit per cause present. The wake causes and their bits are:
  - bit1: RTC alarm;
  - bit2: GPIO wake with `gpio_func[3]`;
  - bit3: button with `pin_func[1]`;
  - bit4: control write with bit1 = 0;
  - bit5: watchdog wake;
  - bit6: supply-monitor wake.
- R7: In ON or SLEEP, a reset cause pulses `stop_seq`. On `seq_done` the state becomes OFF and, if `supply_ok` is high, `start_seq` pulses in the same cycle. The state becomes ON after the second `seq_done`. The ON-source register reads bit7 | bit0 (0x81), and the OFF-source register is unchanged.
- R8: A GPIO or button event with its function-enable bit low has no effect.
- R9: A request that has no meaning in the current state is ignored and leaves both source registers unchanged. Examples are WAKE or ON requests while ON, and OFF or reset requests while OFF.
- R10: When several requests arrive in one cycle, the winner is chosen in this order: OFF, then reset, then SLEEP, then ON/WAKE. At most one strobe is high in any cycle.
- R11: Writing 1s to address 1 (ON-source) or address 2 (OFF-source) clears those bits. When a new capture falls in the same cycle as a clear, the capture wins.
- R12: While a start or stop sequence is running, every event and control write request is ignored.
- R13: `pwr_state` encoding: 0 OFF, 1 ON, 2 SLEEP. Reading address 0 returns bit0 = not OFF and bit1 = SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the start threshold (level) |
| ev_rtc_alarm | input | 1 | RTC alarm pulse |
| ev_gpio_on | input | 1 | GPIO on request pulse |
| ev_gpio_off | input | 1 | GPIO off request pulse |
| ev_gpio_sleep | input | 1 | GPIO sleep request pulse |
| ev_gpio_wake | input | 1 | GPIO wake request pulse |
| gpio_func | input | 4 | GPIO function enables: on, off, sleep, wake |
| ev_pin | input | 1 | Power-button request pulse |
| pin_func | input | 3 | Button function enables: on, wake, off |
| ev_wdog_wake | input | 1 | Watchdog timeout set to wake |
| ev_wdog_rst | input | 1 | Watchdog timeout set to reset |
| ev_hw_rst | input | 1 | Hardware reset request |
| ev_sw_rst | input | 1 | Software reset request |
| ev_cnv_uv | input | 1 | Converter undervoltage reset |
| ev_therm | input | 1 | Thermal shutdown |
| ev_mon_wake | input | 1 | Supply monitor wake request |
| ev_mon_off | input | 1 | Supply monitor off request |
| ev_shdn | input | 1 | Supply below shutdown threshold |
| ev_seq_fail | input | 1 | Power-sequence start-up timeout |
| ev_ldo_err | input | 1 | Internal LDO error |
| seq_done | input | 1 | Start/stop sequence complete handshake |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 ON-source, 2 OFF-source) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| start_seq | output | 1 | Start power-up sequence strobe |
| stop_seq | output | 1 | Start power-down sequence strobe |
| sleep_enter | output | 1 | Sleep entry strobe |
| pwr_state | output | 2 | Current power state |

## Verification
The assertions assume that the event inputs are single-cycle pulses and that `seq_done` arrives only while a sequence is running. They also assume that `supply_ok` changes only at instants well away from any request. The stimulus drives every pulse for exactly one clock, from the falling edge. It raises `seq_done` only after a start or stop strobe has been seen, and it changes `supply_ok` only while the machine is idle. Each strobe the design produces is matched against a queue of expected strobes in order. The source registers are read back through the bus after every transition.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {PS_OFF = 2'd0, PS_ON = 2'd1, PS_SLEEP = 2'd2} pstate_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_STOP = 2'd1, PH_RST_STOP = 2'd2, PH_START = 2'd3} phase_e;

  localparam int SRC_W = 8;

  // ON-source bit positions
  localparam int ONB_FROM_OFF = 0;
  localparam int ONB_RTC      = 1;
  localparam int ONB_GPIO     = 2;
  localparam int ONB_PIN      = 3;
  localparam int ONB_SWWAKE   = 4;
  localparam int ONB_WDOG     = 5;
  localparam int ONB_MON      = 6;
  localparam int ONB_RESET    = 7;

  // OFF-source bit positions
  localparam int OFB_SW    = 0;
  localparam int OFB_PIN   = 1;
  localparam int OFB_THERM = 2;
  localparam int OFB_MON   = 3;
  localparam int OFB_SHDN  = 4;
  localparam int OFB_GPIO  = 5;
  localparam int OFB_SEQ   = 6;
  localparam int OFB_LDO   = 7;

  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_ONSRC  = 1;
  localparam int A_OFFSRC = 2;

  // next value of one write-1-to-clear bit that may also be captured
  function automatic logic w1c_bit(input logic cur, input logic clr,
                                   input logic cap_en, input logic cap_val);
    return cap_en ? cap_val : (cur & ~clr);
  endfunction

  // control readback: bit0 = powered, bit1 = sleeping
  function automatic logic [1:0] ctrl_word(input pstate_e st);
    return {st == PS_SLEEP, st != PS_OFF};
  endfunction
endpackage

// File: rtl/pwr_evt_qualify.sv
module pwr_evt_qualify
  import pwr_pkg::*;
(
  input  pstate_e          state,
  input  logic             busy,
  input  logic             supply_ok,
  input  logic             ev_rtc,
  input  logic             ev_gpio_on,
  input  logic             ev_gpio_off,
  input  logic             ev_gpio_sleep,
  input  logic             ev_gpio_wake,
  input  logic [3:0]       gpio_cfg,
  input  logic             ev_pin,
  input  logic [2:0]       pin_cfg,
  input  logic             sw_off,
  input  logic             sw_sleep,
  input  logic             sw_wake,
  input  logic             ev_wdog_wake,
  input  logic             ev_mon_wake,
  input  logic             ev_wdog_rst,
  input  logic             ev_hw_rst,
  input  logic             ev_sw_rst,
  input  logic             ev_cnv_uv,
  input  logic             ev_therm,
  input  logic             ev_mon_off,
  input  logic             ev_shdn,
  input  logic             ev_seq_fail,
  input  logic             ev_ldo_err,
  output logic [SRC_W-1:0] off_cause,
  output logic [SRC_W-1:0] on_cause,
  output logic             take_off,
  output logic             take_rst,
  output logic             take_sleep,
  output logic             take_on,
  output logic             take_wake
);
  logic idle, in_off, in_on, in_slp, awake;
  logic [SRC_W-1:0] off_raw, on_raw, wake_raw;
  logic rst_any, sleep_any;

  assign idle   = !busy;
  assign in_off = (state == PS_OFF);
  assign in_on  = (state == PS_ON);
  assign in_slp = (state == PS_SLEEP);
  assign awake  = in_on | in_slp;

  always_comb begin
    off_raw = '0;
    off_raw[OFB_SW]    = sw_off;
    off_raw[OFB_PIN]   = ev_pin & pin_cfg[2];
    off_raw[OFB_THERM] = ev_therm;
    off_raw[OFB_MON]   = ev_mon_off;
    off_raw[OFB_SHDN]  = ev_shdn;
    off_raw[OFB_GPIO]  = ev_gpio_off & gpio_cfg[1];
    off_raw[OFB_SEQ]   = ev_seq_fail;
    off_raw[OFB_LDO]   = ev_ldo_err;

    on_raw = '0;
    on_raw[ONB_RTC]  = ev_rtc;
    on_raw[ONB_GPIO] = ev_gpio_on & gpio_cfg[0];
    on_raw[ONB_PIN]  = ev_pin & pin_cfg[0];

    wake_raw = '0;
    wake_raw[ONB_RTC]    = ev_rtc;
    wake_raw[ONB_GPIO]   = ev_gpio_wake & gpio_cfg[3];
    wake_raw[ONB_PIN]    = ev_pin & pin_cfg[1];
    wake_raw[ONB_SWWAKE] = sw_wake;
    wake_raw[ONB_WDOG]   = ev_wdog_wake;
    wake_raw[ONB_MON]    = ev_mon_wake;
  end

  assign rst_any   = ev_wdog_rst | ev_hw_rst | ev_sw_rst | ev_cnv_uv;
  assign sleep_any = sw_sleep | (ev_gpio_sleep & gpio_cfg[2]);

  // every OFF cause of the cycle is kept for capture
  assign off_cause = (idle && awake) ? off_raw : '0;
  assign on_cause  = in_off ? on_raw : wake_raw;

  // arbitration: OFF > reset > SLEEP > ON/WAKE
  assign take_off   = |off_cause;
  assign take_rst   = idle & awake & rst_any & ~take_off;
  assign take_sleep = idle & in_on & sleep_any & ~take_off & ~take_rst;
  assign take_on    = idle & in_off & supply_ok & (|on_raw);
  assign take_wake  = idle & in_slp & supply_ok & (|wake_raw) & ~take_off & ~take_rst;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    supply_ok,
  input  logic    seq_done,
  input  logic    take_off,
  input  logic    take_rst,
  input  logic    take_sleep,
  input  logic    take_on,
  input  logic    take_wake,
  output pstate_e state,
  output logic    busy,
  output logic    start_seq,
  output logic    stop_seq,
  output logic    sleep_enter
);
  phase_e phase;

  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PS_OFF;
      phase       <= PH_IDLE;
      start_seq   <= 1'b0;
      stop_seq    <= 1'b0;
      sleep_enter <= 1'b0;
    end else begin
      start_seq   <= 1'b0;
      stop_seq    <= 1'b0;
      sleep_enter <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (take_off) begin
            phase    <= PH_STOP;
            stop_seq <= 1'b1;
          end else if (take_rst) begin
            phase    <= PH_RST_STOP;
            stop_seq <= 1'b1;
          end else if (take_sleep) begin
            state       <= PS_SLEEP;
            sleep_enter <= 1'b1;
          end else if (take_on || take_wake) begin
            phase     <= PH_START;
            start_seq <= 1'b1;
          end
        end
        PH_STOP: begin
          if (seq_done) begin
            state <= PS_OFF;
            phase <= PH_IDLE;
          end
        end
        PH_RST_STOP: begin
          if (seq_done) begin
            state <= PS_OFF;
            if (supply_ok) begin
              phase     <= PH_START;
              start_seq <= 1'b1;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: begin
          if (seq_done) begin
            state <= PS_ON;
            phase <= PH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_src_regs.sv
module pwr_src_regs
  import pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_on,
  input  logic             clr_off,
  input  logic [SRC_W-1:0] clr_mask,
  input  logic             take_off,
  input  logic             take_rst,
  input  logic             take_on,
  input  logic             take_wake,
  input  logic [SRC_W-1:0] off_cause,
  input  logic [SRC_W-1:0] on_cause,
  output logic [SRC_W-1:0] on_src,
  output logic [SRC_W-1:0] off_src
);
  logic             on_cap;
  logic [SRC_W-1:0] on_next;

  assign on_cap = take_on | take_wake | take_rst;

  always_comb begin
    on_next = '0;
    if (take_rst) begin
      on_next[ONB_RESET]    = 1'b1;
      on_next[ONB_FROM_OFF] = 1'b1;
    end else begin
      on_next = on_cause;
      on_next[ONB_FROM_OFF] = take_on;
    end
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_src[i]  <= 1'b0;
        off_src[i] <= 1'b0;
      end else begin
        on_src[i]  <= w1c_bit(on_src[i], clr_on & clr_mask[i], on_cap, on_next[i]);
        off_src[i] <= w1c_bit(off_src[i], clr_off & clr_mask[i], take_off, off_cause[i]);
      end
    end
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              ev_rtc_alarm,
  input  logic              ev_gpio_on,
  input  logic              ev_gpio_off,
  input  logic              ev_gpio_sleep,
  input  logic              ev_gpio_wake,
  input  logic [3:0]        gpio_func,
  input  logic              ev_pin,
  input  logic [2:0]        pin_func,
  input  logic              ev_wdog_wake,
  input  logic              ev_wdog_rst,
  input  logic              ev_hw_rst,
  input  logic              ev_sw_rst,
  input  logic              ev_cnv_uv,
  input  logic              ev_therm,
  input  logic              ev_mon_wake,
  input  logic              ev_mon_off,
  input  logic              ev_shdn,
  input  logic              ev_seq_fail,
  input  logic              ev_ldo_err,
  input  logic              seq_done,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              start_seq,
  output logic              stop_seq,
  output logic              sleep_enter,
  output logic [1:0]        pwr_state
);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_ON   = ADDR_W'(A_ONSRC);
  localparam logic [ADDR_W-1:0] AD_OFF  = ADDR_W'(A_OFFSRC);

  pstate_e          state;
  logic             busy;
  logic             sw_wr, sw_off, sw_sleep, sw_wake;
  logic             take_off, take_rst, take_sleep, take_on, take_wake;
  logic [SRC_W-1:0] off_cause, on_cause, on_src, off_src;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign sw_wr    = reg_wr && (reg_addr == AD_CTRL);
  assign sw_off   = sw_wr & ~reg_wdata[0];
  assign sw_sleep = sw_wr &  reg_wdata[1];
  assign sw_wake  = sw_wr & ~reg_wdata[1];

  pwr_evt_qualify u_qual (
    .state(state), .busy(busy), .supply_ok(supply_ok),
    .ev_rtc(ev_rtc_alarm), .ev_gpio_on(ev_gpio_on), .ev_gpio_off(ev_gpio_off),
    .ev_gpio_sleep(ev_gpio_sleep), .ev_gpio_wake(ev_gpio_wake), .gpio_cfg(gpio_func),
    .ev_pin(ev_pin), .pin_cfg(pin_func),
    .sw_off(sw_off), .sw_sleep(sw_sleep), .sw_wake(sw_wake),
    .ev_wdog_wake(ev_wdog_wake), .ev_mon_wake(ev_mon_wake),
    .ev_wdog_rst(ev_wdog_rst), .ev_hw_rst(ev_hw_rst), .ev_sw_rst(ev_sw_rst),
    .ev_cnv_uv(ev_cnv_uv), .ev_therm(ev_therm), .ev_mon_off(ev_mon_off),
    .ev_shdn(ev_shdn), .ev_seq_fail(ev_seq_fail), .ev_ldo_err(ev_ldo_err),
    .off_cause(off_cause), .on_cause(on_cause),
    .take_off(take_off), .take_rst(take_rst), .take_sleep(take_sleep),
    .take_on(take_on), .take_wake(take_wake)
  );

  pwr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .seq_done(seq_done),
    .take_off(take_off), .take_rst(take_rst), .take_sleep(take_sleep),
    .take_on(take_on), .take_wake(take_wake),
    .state(state), .busy(busy),
    .start_seq(start_seq), .stop_seq(stop_seq), .sleep_enter(sleep_enter)
  );

  pwr_src_regs u_src (
    .clk(clk), .rst_n(rst_n),
    .clr_on(reg_wr && (reg_addr == AD_ON)),
    .clr_off(reg_wr && (reg_addr == AD_OFF)),
    .clr_mask(reg_wdata[SRC_W-1:0]),
    .take_off(take_off), .take_rst(take_rst), .take_on(take_on), .take_wake(take_wake),
    .off_cause(off_cause), .on_cause(on_cause),
    .on_src(on_src), .off_src(off_src)
  );

  assign pwr_state = state;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AD_CTRL)     reg_rdata = DATA_W'(ctrl_word(state));
    else if (reg_addr == AD_ON)  reg_rdata = DATA_W'(on_src);
    else if (reg_addr == AD_OFF) reg_rdata = DATA_W'(off_src);
  end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       reg_wr,
  input logic       busy,
  input logic       start_seq,
  input logic       stop_seq,
  input logic       sleep_enter,
  input logic [1:0] pwr_state,
  input logic [7:0] on_src,
  input logic [7:0] off_src
);
  assert_onehot_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_seq, stop_seq, sleep_enter}));

  assert_start_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_seq |-> $past(supply_ok));

  assert_sleep_from_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |-> (pwr_state == 2'd2 && $past(pwr_state) == 2'd1));

  assert_sleep_unlogged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_enter && !$past(reg_wr)) |-> ($stable(off_src) && $stable(on_src)));

  assert_on_via_sequence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'd0 && pwr_state != 2'd0) |-> $past(busy));

  assert_stop_only_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seq |-> $past(pwr_state) != 2'd0);

  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !(stop_seq || sleep_enter));

  assert_start_keeps_off_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seq && !$past(reg_wr)) |-> $stable(off_src));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .reg_wr(reg_wr), .busy(busy),
  .start_seq(start_seq), .stop_seq(stop_seq), .sleep_enter(sleep_enter),
  .pwr_state(pwr_state), .on_src(on_src), .off_src(off_src)
);

// File: tb/tb_pwr_state_ctrl.sv
module tb_pwr_state_ctrl;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, supply_ok;
  logic ev_rtc_alarm, ev_gpio_on, ev_gpio_off, ev_gpio_sleep, ev_gpio_wake;
  logic [3:0] gpio_func;
  logic ev_pin;
  logic [2:0] pin_func;
  logic ev_wdog_wake, ev_wdog_rst, ev_hw_rst, ev_sw_rst, ev_cnv_uv;
  logic ev_therm, ev_mon_wake, ev_mon_off, ev_shdn, ev_seq_fail, ev_ldo_err;
  logic seq_done, reg_wr;
  logic [1:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic start_seq, stop_seq, sleep_enter;
  logic [1:0] pwr_state;

  pwr_state_ctrl dut (.*);

  int total = 0, bad = 0;
  int exp_kind[$];
  string exp_tag[$];
  bit ended = 0;

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // 1 = start, 2 = stop, 3 = sleep entry
  task automatic expect_strobe(int kind, string tag);
    exp_kind.push_back(kind);
    exp_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && (start_seq || stop_seq || sleep_enter)) begin
      int k;
      k = start_seq ? 1 : (stop_seq ? 2 : 3);
      total++;
      if (start_seq + stop_seq + sleep_enter > 1) begin
        bad++;
        $display("FAIL R10: several strobes at once got %0d expected 1", start_seq + stop_seq + sleep_enter);
      end else if (exp_kind.size() == 0) begin
        bad++;
        $display("FAIL R9/R12: unexpected strobe got kind %0d expected none", k);
      end else begin
        int e;
        string t;
        e = exp_kind.pop_front();
        t = exp_tag.pop_front();
        if (k != e) begin
          bad++;
          $display("FAIL %s: strobe kind got %0d expected %0d", t, k, e);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(int a, output int v);
    reg_addr = 2'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = 16'(d);
    tick();
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic done_seq();
    repeat (3) tick();
    seq_done = 1;
    tick();
    seq_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 0; supply_ok = 0;
    {ev_rtc_alarm, ev_gpio_on, ev_gpio_off, ev_gpio_sleep, ev_gpio_wake, ev_pin} = '0;
    {ev_wdog_wake, ev_wdog_rst, ev_hw_rst, ev_sw_rst, ev_cnv_uv} = '0;
    {ev_therm, ev_mon_wake, ev_mon_off, ev_shdn, ev_seq_fail, ev_ldo_err} = '0;
    gpio_func = '0; pin_func = '0; seq_done = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 / R13 reset state
    chk("R1 state", pwr_state, 0);
    rd(1, v); chk("R1 on_src", v, 0);
    rd(2, v); chk("R1 off_src", v, 0);
    rd(0, v); chk("R13 ctrl read OFF", v, 0);

    // R3 supply low blocks ON
    ev_rtc_alarm = 1; tick(); ev_rtc_alarm = 0; tick();
    chk("R3 state stays OFF", pwr_state, 0);
    rd(1, v); chk("R3 on_src unchanged", v, 0);

    // R8 disabled GPIO function
    supply_ok = 1;
    ev_gpio_on = 1; tick(); ev_gpio_on = 0; tick();
    chk("R8 gpio disabled", pwr_state, 0);
    rd(1, v); chk("R8 on_src unchanged", v, 0);

    // R2 RTC alarm from OFF, R12 event during sequence
    expect_strobe(1, "R2");
    ev_rtc_alarm = 1; tick(); ev_rtc_alarm = 0;
    rd(1, v); chk("R2 on_src rtc+from_off", v, 'h03);
    gpio_func = 4'b1111;
    ev_gpio_on = 1; tick(); ev_gpio_on = 0;
    chk("R12 busy ignores", pwr_state, 0);
    rd(1, v); chk("R12 on_src unchanged", v, 'h03);
    done_seq();
    chk("R2 state ON", pwr_state, 1);

    // R9 wake request in ON ignored
    ev_wdog_wake = 1; tick(); ev_wdog_wake = 0; tick();
    rd(1, v); chk("R9 on_src unchanged", v, 'h03);
    chk("R9 still ON", pwr_state, 1);

    // R11 write-1-to-clear
    wr(1, 'h01);
    rd(1, v); chk("R11 on_src clear", v, 'h02);

    // R5 / R13 software sleep
    expect_strobe(3, "R5");
    wr(0, 3);
    chk("R5 state SLEEP", pwr_state, 2);
    rd(2, v); chk("R5 off_src unlogged", v, 0);
    rd(1, v); chk("R5 on_src unlogged", v, 'h02);
    rd(0, v); chk("R13 ctrl read SLEEP", v, 3);

    // R6 watchdog wake
    expect_strobe(1, "R6");
    ev_wdog_wake = 1; tick(); ev_wdog_wake = 0;
    rd(1, v); chk("R6 on_src wdog", v, 'h20);
    done_seq();
    chk("R6 state ON", pwr_state, 1);

    // R4 / R10 multiple causes with sleep and rtc present
    expect_strobe(2, "R10");
    ev_therm = 1; ev_ldo_err = 1; ev_gpio_sleep = 1; ev_rtc_alarm = 1; tick();
    {ev_therm, ev_ldo_err, ev_gpio_sleep, ev_rtc_alarm} = '0;
    rd(2, v); chk("R4 off_src therm+ldo", v, 'h84);
    rd(1, v); chk("R4 on_src untouched", v, 'h20);
    done_seq();
    chk("R4 state OFF", pwr_state, 0);

    // R9 OFF cause while OFF
    ev_therm = 1; tick(); ev_therm = 0; tick();
    chk("R9 OFF stays OFF", pwr_state, 0);

    // R8 / R2 button enabled for ON
    pin_func = 3'b001;
    expect_strobe(1, "R8");
    ev_pin = 1; tick(); ev_pin = 0;
    rd(1, v); chk("R8 on_src pin", v, 'h09);
    done_seq();
    chk("R8 state ON", pwr_state, 1);

    // R7 software reset: stop then start
    expect_strobe(2, "R7 stop");
    expect_strobe(1, "R7 start");
    ev_sw_rst = 1; tick(); ev_sw_rst = 0;
    rd(1, v); chk("R7 on_src reset", v, 'h81);
    rd(2, v); chk("R7 off_src kept", v, 'h84);
    done_seq();
    chk("R7 OFF between", pwr_state, 0);
    done_seq();
    chk("R7 state ON", pwr_state, 1);

    // R11 clear on off_src
    wr(2, 'h04);
    rd(2, v); chk("R11 off_src clear", v, 'h80);

    // R5 GPIO sleep, R3 wake blocked, R6 software wake
    expect_strobe(3, "R5 gpio");
    ev_gpio_sleep = 1; tick(); ev_gpio_sleep = 0;
    chk("R5 gpio sleep", pwr_state, 2);
    supply_ok = 0;
    ev_rtc_alarm = 1; tick(); ev_rtc_alarm = 0; tick();
    chk("R3 wake blocked", pwr_state, 2);
    rd(1, v); chk("R3 on_src kept", v, 'h81);
    supply_ok = 1;
    expect_strobe(1, "R6 sw");
    wr(0, 1);
    rd(1, v); chk("R6 on_src sw wake", v, 'h10);
    done_seq();
    chk("R6 sw wake ON", pwr_state, 1);
    rd(0, v); chk("R13 ctrl read ON", v, 1);

    repeat (3) tick();
    chk("R10 strobe queue drained", exp_kind.size(), 0);
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule